// File: doc/BRIEF.md
# Two-Level Paging Translator with Translation Cache

This block converts a 32-bit linear address into a physical address for one access at a time. The top ten bits of the linear address select an entry in a page directory, the next ten select an entry in a page table, and the low twelve bits pass through as the offset inside a 4 KB page. The directory's physical base arrives on an input that the surrounding logic holds steady. A fully associative cache of recent translations sits in front of the table walk. A request that hits in the cache and needs no memory update is answered without any memory traffic.

On a miss, the block walks the tables over a simple word-wide memory port. It reads the directory entry and then the table entry. It applies the combined user/supervisor and read/write rules of both levels. It writes back any Accessed or Dirty bit that must be set, fills the cache, and then answers. A faulting access is answered with a cause code and changes neither memory nor the cache. A flush input empties the cache, for example after software edits the tables.

Top module: `pg_xlate`

## Requirements
- R1: A successful response carries rsp_phys = {frame bits 31..12 of the table entry, req_lin[11:0]}, where req_lin[31:22] indexes the directory and req_lin[21:12] indexes the table.
- R2: An entry whose Present bit (bit 0) is 0 at either level gives rsp_fault=1, rsp_cause=2'b01 and rsp_phys=0, with no memory write. A directory entry that is not present stops the walk after one read.
- R3: Supervisor accesses (req_user=0) are always allowed. A user access faults with cause 2'b10 unless both levels have U/S (bit 2) set. A user write faults with cause 2'b11 unless both levels have R/W (bit 1) set.
- R4: The walk reads the directory entry at {dir_base[31:12], req_lin[31:22], 2'b00} and then the table entry at {directory entry[31:12], req_lin[21:12], 2'b00}. The memory request and address stay steady until mem_ack.
- R5: A completed walked access writes the directory entry back only if its Accessed bit (bit 5) is clear. It writes the table entry back only if Accessed is clear, or if the access is a write and Dirty (bit 6) is clear. Each write-back sets Accessed, and the table entry also gets Dirty on a write.
- R6: A cache hit that needs no write-back makes no memory access. rsp_valid rises at the second clock edge after the request is accepted.
- R7: The cache holds TLB_DEPTH (32) translations and replaces them in round-robin order, starting at slot 0 after reset or flush.
- R8: A write that hits a cached translation whose Dirty flag is clear forces a walk that sets Dirty in memory and updates that same slot. A later write to that page hits with no memory access.
- R9: A flush pulse invalidates every cached translation, so the next access walks and sees the current table contents.
- R10: req_ready is high only while the block is idle. rsp_valid is a one-cycle pulse.
- R11: A response without a fault carries cause 2'b00. When several faults apply, not-present has priority over a supervisor-page violation, which has priority over a read-only violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| dir_base | input | 32 | Physical base of the page directory (bits 31..12 used) |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user access, 0 = supervisor |
| rsp_valid | output | 1 | Response pulse |
| rsp_phys | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Access faulted |
| rsp_cause | output | 2 | 00 none, 01 not present, 10 supervisor page, 11 read-only |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid this cycle |
| mem_rdata | input | 32 | Read data |

## Verification
The checks assume that mem_ack is raised only while mem_req is high, and for one cycle per access. The bench's memory model answers each request with a single-cycle acknowledge one edge later, and drops it at the next edge. The checks also assume that dir_base and the in-memory tables do not change during a walk. The stimulus changes table words only between requests, while the block is idle. Requests are issued one at a time, and only once req_ready is high, so the response pulse can be tied to the request that caused it.

// File: rtl/pg_xlate_pkg.sv
package pg_xlate_pkg;

    localparam int LIN_W = 32;
    localparam int OFF_W = 12;
    localparam int IDX_W = 10;
    localparam int VPN_W = LIN_W - OFF_W;
    localparam int PFN_W = LIN_W - OFF_W;

    // entry bit positions (walk hardware depends on them)
    localparam int BIT_P   = 0;
    localparam int BIT_RW  = 1;
    localparam int BIT_US  = 2;
    localparam int BIT_ACC = 5;
    localparam int BIT_DRT = 6;

    localparam logic [LIN_W-1:0] ACC_MASK = LIN_W'(1) << BIT_ACC;
    localparam logic [LIN_W-1:0] DRT_MASK = LIN_W'(1) << BIT_DRT;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_RD_DIR,
        ST_RD_TBL,
        ST_WR_DIR,
        ST_WR_TBL,
        ST_FILL
    } walk_st_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_ABSENT = 2'b01,
        CAUSE_PRIV   = 2'b10,
        CAUSE_RDONLY = 2'b11
    } flt_cause_e;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             us;
        logic             rw;
        logic             dirty;
    } tlb_data_t;

endpackage

// File: rtl/pg_perm.sv
module pg_perm
    import pg_xlate_pkg::*;
(
    input  logic       usr,
    input  logic       wr,
    input  logic       us,
    input  logic       rw,
    output flt_cause_e cause
);

    always_comb begin
        cause = CAUSE_NONE;
        if (usr) begin
            if (!us) begin
                cause = CAUSE_PRIV;
            end else if (wr && !rw) begin
                cause = CAUSE_RDONLY;
            end
        end
    end

endmodule

// File: rtl/pg_tlb.sv
module pg_tlb
    import pg_xlate_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [IW-1:0]    hit_idx,
    output tlb_data_t        hit_data,
    input  logic             fill_en,
    input  logic             fill_reuse,
    input  logic [IW-1:0]    fill_idx,
    input  logic [VPN_W-1:0] fill_vpn,
    input  tlb_data_t        fill_data,
    output logic [DEPTH-1:0] vld_o
);

    typedef struct packed {
        logic [DEPTH-1:0] vld;
        logic [IW-1:0]    rr;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic [VPN_W-1:0] tag_d [DEPTH];
    logic [VPN_W-1:0] tag_q [DEPTH];
    tlb_data_t        dat_d [DEPTH];
    tlb_data_t        dat_q [DEPTH];
    logic [DEPTH-1:0] match;
    logic [IW-1:0]    sel;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = ctl_q.vld[g] && (tag_q[g] == lk_vpn);
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) hit_idx = IW'(i);
        end
        hit_data = dat_q[hit_idx];
    end

    assign sel = fill_reuse ? fill_idx : ctl_q.rr;

    always_comb begin
        ctl_d = ctl_q;
        tag_d = tag_q;
        dat_d = dat_q;
        if (flush) begin
            ctl_d.vld = '0;
            ctl_d.rr  = '0;
        end else if (fill_en) begin
            ctl_d.vld[sel] = 1'b1;
            tag_d[sel]     = fill_vpn;
            dat_d[sel]     = fill_data;
            if (!fill_reuse) begin
                ctl_d.rr = (ctl_q.rr == IW'(DEPTH - 1)) ? '0 : ctl_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk) begin
        tag_q <= tag_d;
        dat_q <= dat_d;
    end

    assign vld_o = ctl_q.vld;

endmodule

// File: rtl/pg_xlate.sv
module pg_xlate
    import pg_xlate_pkg::*;
#(
    parameter int TLB_DEPTH = 32,
    localparam int IW       = (TLB_DEPTH > 1) ? $clog2(TLB_DEPTH) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic [31:0] dir_base,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_lin,
    input  logic        req_write,
    input  logic        req_user,
    output logic        rsp_valid,
    output logic [31:0] rsp_phys,
    output logic        rsp_fault,
    output logic [1:0]  rsp_cause,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);

    typedef struct packed {
        walk_st_e         st;
        logic [LIN_W-1:0] lin;
        logic             wr;
        logic             usr;
        logic [31:0]      pde;
        logic [31:0]      pte;
        logic             reuse;
        logic [IW-1:0]    ridx;
        logic             rsp_v;
        logic [31:0]      rsp_pa;
        flt_cause_e       rsp_c;
    } st_t;

    st_t q, d;

    logic [VPN_W-1:0]  vpn;
    logic [IDX_W-1:0]  dir_idx, tbl_idx;
    logic [OFF_W-1:0]  off;
    logic              tlb_hit;
    logic [IW-1:0]     tlb_hidx;
    tlb_data_t         tlb_hdat;
    tlb_data_t         fill_data;
    logic              fill_en;
    logic [TLB_DEPTH-1:0] tlb_vld;
    flt_cause_e        hit_cause, walk_cause;
    logic              unused_base;

    assign unused_base = ^dir_base[OFF_W-1:0];

    assign vpn     = q.lin[LIN_W-1:OFF_W];
    assign dir_idx = q.lin[LIN_W-1 -: IDX_W];
    assign tbl_idx = q.lin[OFF_W +: IDX_W];
    assign off     = q.lin[OFF_W-1:0];

    pg_tlb #(.DEPTH(TLB_DEPTH)) u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .lk_vpn     (vpn),
        .hit        (tlb_hit),
        .hit_idx    (tlb_hidx),
        .hit_data   (tlb_hdat),
        .fill_en    (fill_en),
        .fill_reuse (q.reuse),
        .fill_idx   (q.ridx),
        .fill_vpn   (vpn),
        .fill_data  (fill_data),
        .vld_o      (tlb_vld)
    );

    pg_perm u_perm_hit (
        .usr   (q.usr),
        .wr    (q.wr),
        .us    (tlb_hdat.us),
        .rw    (tlb_hdat.rw),
        .cause (hit_cause)
    );

    // table entry arrives on mem_rdata while in ST_RD_TBL
    pg_perm u_perm_walk (
        .usr   (q.usr),
        .wr    (q.wr),
        .us    (q.pde[BIT_US] & mem_rdata[BIT_US]),
        .rw    (q.pde[BIT_RW] & mem_rdata[BIT_RW]),
        .cause (walk_cause)
    );

    function automatic logic tbl_needs_wb(input logic [31:0] e, input logic w);
        return !e[BIT_ACC] || (w && !e[BIT_DRT]);
    endfunction

    assign fill_en   = (q.st == ST_FILL);
    assign fill_data = '{pfn:   q.pte[31:OFF_W],
                         us:    q.pde[BIT_US] & q.pte[BIT_US],
                         rw:    q.pde[BIT_RW] & q.pte[BIT_RW],
                         dirty: q.pte[BIT_DRT] | q.wr};

    // memory port decode
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {q.pde[31:OFF_W], tbl_idx, 2'b00};
        mem_wdata = '0;
        unique case (q.st)
            ST_RD_DIR: begin
                mem_req  = 1'b1;
                mem_addr = {dir_base[31:OFF_W], dir_idx, 2'b00};
            end
            ST_RD_TBL: mem_req = 1'b1;
            ST_WR_DIR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {dir_base[31:OFF_W], dir_idx, 2'b00};
                mem_wdata = q.pde | ACC_MASK;
            end
            ST_WR_TBL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = q.pte | ACC_MASK | (q.wr ? DRT_MASK : '0);
            end
            default: ;
        endcase
    end

    // next-state logic
    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.lin = req_lin;
                    d.wr  = req_write;
                    d.usr = req_user;
                    d.st  = ST_LOOK;
                end
            end
            ST_LOOK: begin
                d.reuse = 1'b0;
                if (tlb_hit && hit_cause != CAUSE_NONE) begin
                    d.rsp_v  = 1'b1;
                    d.rsp_pa = '0;
                    d.rsp_c  = hit_cause;
                    d.st     = ST_IDLE;
                end else if (tlb_hit && !(q.wr && !tlb_hdat.dirty)) begin
                    d.rsp_v  = 1'b1;
                    d.rsp_pa = {tlb_hdat.pfn, off};
                    d.rsp_c  = CAUSE_NONE;
                    d.st     = ST_IDLE;
                end else begin
                    d.reuse = tlb_hit;
                    d.ridx  = tlb_hidx;
                    d.st    = ST_RD_DIR;
                end
            end
            ST_RD_DIR: begin
                if (mem_ack) begin
                    d.pde = mem_rdata;
                    if (!mem_rdata[BIT_P]) begin
                        d.rsp_v  = 1'b1;
                        d.rsp_pa = '0;
                        d.rsp_c  = CAUSE_ABSENT;
                        d.st     = ST_IDLE;
                    end else begin
                        d.st = ST_RD_TBL;
                    end
                end
            end
            ST_RD_TBL: begin
                if (mem_ack) begin
                    d.pte = mem_rdata;
                    if (!mem_rdata[BIT_P] || walk_cause != CAUSE_NONE) begin
                        d.rsp_v  = 1'b1;
                        d.rsp_pa = '0;
                        d.rsp_c  = !mem_rdata[BIT_P] ? CAUSE_ABSENT : walk_cause;
                        d.st     = ST_IDLE;
                    end else if (!q.pde[BIT_ACC]) begin
                        d.st = ST_WR_DIR;
                    end else if (tbl_needs_wb(mem_rdata, q.wr)) begin
                        d.st = ST_WR_TBL;
                    end else begin
                        d.st = ST_FILL;
                    end
                end
            end
            ST_WR_DIR: begin
                if (mem_ack) begin
                    d.st = tbl_needs_wb(q.pte, q.wr) ? ST_WR_TBL : ST_FILL;
                end
            end
            ST_WR_TBL: begin
                if (mem_ack) d.st = ST_FILL;
            end
            ST_FILL: begin
                d.rsp_v  = 1'b1;
                d.rsp_pa = {q.pte[31:OFF_W], off};
                d.rsp_c  = CAUSE_NONE;
                d.st     = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = q.rsp_v;
    assign rsp_phys  = q.rsp_pa;
    assign rsp_cause = q.rsp_c;
    assign rsp_fault = (q.rsp_c != CAUSE_NONE);

endmodule

// File: rtl/pg_xlate_chk.sv
module pg_xlate_chk #(
    parameter int DEPTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [31:0]      rsp_phys,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic [31:0]      mem_addr,
    input logic [31:0]      mem_wdata,
    input logic [DEPTH-1:0] tlb_vld
);

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10

    AST_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready); // R10

    AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R4

    AST_WB_SETS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[5]); // R5

    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req); // R6

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tlb_vld == '0)); // R9

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_phys == '0)); // R2

endmodule

bind pg_xlate pg_xlate_chk #(.DEPTH(TLB_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_phys  (rsp_phys),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .tlb_vld   (tlb_vld)
);

// File: tb/pg_xlate_tb.sv
`timescale 1ns/1ps
module pg_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flush;
    logic [31:0] dir_base;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_lin;
    logic        req_write;
    logic        req_user;
    logic        rsp_valid;
    logic [31:0] rsp_phys;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    always #4 clk = ~clk;

    pg_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .dir_base(dir_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
        .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_phys(rsp_phys), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;

    logic [31:0] mem [logic [29:0]];

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return mem.exists(a[31:2]) ? mem[a[31:2]] : 32'h0;
    endfunction

    function automatic logic [31:0] mk_ent(input logic [19:0] frame, input logic us, rw, p);
        return {frame, 9'b0, us, rw, p};
    endfunction

    // memory model: single-cycle acknowledge one edge after the request
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[31:2]] = mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem_word(mem_addr);
                rd_cnt <= rd_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct {
        logic [31:0] pa;
        logic [1:0]  cs;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // monitor: compares every response against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected response", rsp_phys, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rsp_phys == e.pa, {e.tag, " phys"}, rsp_phys, e.pa);
                chk(rsp_cause == e.cs, {e.tag, " cause"}, 32'(rsp_cause), 32'(e.cs));
                chk(rsp_fault == (e.cs != 2'b00), {e.tag, " fault R11"},
                    32'(rsp_fault), 32'(e.cs != 2'b00));
            end
        end
    end

    task automatic do_req(input logic [31:0] lin, input logic wr, usr,
                          input logic [31:0] epa, input logic [1:0] ecs,
                          input int erd, ewr, input string tag);
        int   rd0, wr0, lat;
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        e.pa = epa; e.cs = ecs; e.tag = tag;
        exp_q.push_back(e);
        req_valid = 1'b1; req_lin = lin; req_write = wr; req_user = usr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 500) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        if (erd >= 0) chk((rd_cnt - rd0) == erd, {tag, " reads"}, 32'(rd_cnt - rd0), 32'(erd));
        if (ewr >= 0) chk((wr_cnt - wr0) == ewr, {tag, " writes"}, 32'(wr_cnt - wr0), 32'(ewr));
        if (erd == 0) chk(lat == 1, {tag, " R6 hit latency"}, 32'(lat), 32'd1);
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    localparam logic [31:0] DIR = 32'h0001_0000;
    localparam logic [31:0] TB0 = 32'h0002_0000;

    initial begin
        rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0;
        req_lin = '0; req_write = 1'b0; req_user = 1'b0;
        dir_base = DIR;
        // directory
        mem[(DIR + 0) >> 2]  = mk_ent(20'h00020, 1, 1, 1);
        mem[(DIR + 4) >> 2]  = 32'h0;
        mem[(DIR + 8) >> 2]  = mk_ent(20'h00030, 1, 0, 1);
        mem[(DIR + 12) >> 2] = mk_ent(20'h00040, 0, 1, 1);
        // table 0
        for (int i = 0; i < 50; i++) mem[(TB0 + 4 * i) >> 2] = mk_ent(20'h100 + i, 1, 1, 1);
        mem[(TB0 + 4 * 50) >> 2] = mk_ent(20'h132, 0, 1, 1);
        mem[(TB0 + 4 * 51) >> 2] = mk_ent(20'h133, 1, 0, 1);
        mem[(TB0 + 4 * 52) >> 2] = 32'h0;
        mem[(TB0 + 4 * 53) >> 2] = mk_ent(20'h135, 0, 0, 1);
        mem[32'h0003_0000 >> 2]  = mk_ent(20'h200, 1, 1, 1);
        mem[32'h0004_0000 >> 2]  = 32'h0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 reset ready", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R10 reset rsp", 32'(rsp_valid), 32'd0);
        chk(mem_req == 1'b0, "R6 reset mem idle", 32'(mem_req), 32'd0);

        // R1 R4 R5: first walk sets Accessed in both levels
        do_req(32'h0000_3123, 0, 0, 32'h0010_3123, 2'b00, 2, 2, "R1 R4 sup read p3");
        chk(mem_word(DIR)[5] == 1'b1, "R5 dir acc", mem_word(DIR), 32'h20);
        chk(mem_word(TB0 + 12)[6:5] == 2'b01, "R5 tbl acc only", mem_word(TB0 + 12), 32'h20);
        // R6 hit
        do_req(32'h0000_3ffc, 0, 1, 32'h0010_3ffc, 2'b00, 0, 0, "R6 user read hit p3");
        // R5 dir already accessed: only table written
        do_req(32'h0000_4010, 0, 1, 32'h0010_4010, 2'b00, 2, 1, "R5 read p4");
        // R8 write hit with clean entry re-walks
        do_req(32'h0000_3004, 1, 1, 32'h0010_3004, 2'b00, 2, 1, "R8 write rewalk p3");
        chk(mem_word(TB0 + 12)[6] == 1'b1, "R8 dirty set", mem_word(TB0 + 12), 32'h60);
        do_req(32'h0000_3008, 1, 1, 32'h0010_3008, 2'b00, 0, 0, "R8 write hit p3");

        // R3 supervisor page
        do_req(32'h0003_2040, 0, 1, 32'h0, 2'b10, 2, 0, "R3 user read sup page");
        do_req(32'h0003_2040, 1, 0, 32'h0013_2040, 2'b00, 2, 1, "R3 sup write sup page");
        chk(mem_word(TB0 + 200)[6:5] == 2'b11, "R5 write sets acc+dirty", mem_word(TB0 + 200), 32'h60);
        do_req(32'h0003_2040, 0, 1, 32'h0, 2'b10, 0, 0, "R3 R6 user hit sup page");
        // R3 read-only
        do_req(32'h0003_3abc, 1, 1, 32'h0, 2'b11, 2, 0, "R3 user write rdonly");
        do_req(32'h0003_3abc, 0, 1, 32'h0013_3abc, 2'b00, 2, 1, "R3 user read rdonly");
        do_req(32'h0003_3abc, 1, 0, 32'h0013_3abc, 2'b00, 2, 1, "R3 sup write rdonly");
        // R2 not present
        do_req(32'h0003_4000, 0, 0, 32'h0, 2'b01, 2, 0, "R2 table absent");
        do_req(32'h0040_0000, 0, 0, 32'h0, 2'b01, 1, 0, "R2 R4 dir absent");
        // R3 combined levels; R4 second table
        do_req(32'h0080_0100, 1, 1, 32'h0, 2'b11, 2, 0, "R3 dir rdonly user write");
        do_req(32'h0080_0100, 0, 1, 32'h0020_0100, 2'b00, 2, 2, "R4 R1 table two read");
        // R11 priorities
        do_req(32'h00C0_0000, 0, 1, 32'h0, 2'b01, 2, 0, "R11 absent over priv");
        do_req(32'h0003_5000, 1, 1, 32'h0, 2'b10, 2, 0, "R11 priv over rdonly");

        // R9 stale entry then flush
        mem[(TB0 + 12) >> 2] = mk_ent(20'h777, 1, 1, 1) | 32'h60;
        do_req(32'h0000_3010, 0, 0, 32'h0010_3010, 2'b00, 0, 0, "R9 stale before flush");
        pulse_flush();
        do_req(32'h0000_3010, 0, 0, 32'h0077_7010, 2'b00, 2, 0, "R9 walk after flush");
        mem[(TB0 + 12) >> 2] = mk_ent(20'h103, 1, 1, 1) | 32'h60;

        // R7 round robin
        pulse_flush();
        for (int i = 0; i < 32; i++)
            do_req(32'(i) << 12, 0, 0, (32'h100 + 32'(i)) << 12, 2'b00, 2, -1, "R7 fill");
        do_req(32'h0002_0000, 0, 0, 32'h0012_0000, 2'b00, 2, -1, "R7 evict slot0");
        do_req(32'h0000_5000, 0, 0, 32'h0010_5000, 2'b00, 0, 0, "R7 p5 kept");
        do_req(32'h0000_0000, 0, 0, 32'h0010_0000, 2'b00, 2, -1, "R7 p0 evicted");
        do_req(32'h0001_f000, 0, 0, 32'h0011_f000, 2'b00, 0, 0, "R7 p31 kept");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all responses seen", 32'(exp_q.size()), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule